// File: doc/BRIEF.md
# Machine-Cycle Timer/Event Counter

This block is a 16-bit up-counter that a host reaches through a small byte-wide register port. The count is split into a low byte and a high byte, each readable and writable on its own. A control register picks the count source, enables counting and holds a sticky overflow flag.

In timer mode the count advances once per machine cycle. A machine cycle is a fixed group of clock periods, twelve by default. In event mode the external pin is sampled once per machine cycle at a fixed phase. A falling edge is recognised when one sample is high and the next sample is low. Because detection works on samples rather than on the pin itself, the fastest input the block can count has a period of two machine cycles.

When the count steps past its all-ones value it does not return to zero. Instead it takes the value held in a 16-bit reload register and raises the overflow flag.

Top module: `mc_timer`

## Requirements
- R1: After a synchronous reset the count, the reload value, the run bit, the mode bit and the overflow flag all read as zero, and the held previous pin sample is low.
- R2: With run set and mode clear, the count advances by exactly one every 12 clocks. The step takes effect at the first clock of each machine cycle, which is phase 0 of 12; the phase counter starts at 0 when reset is released.
- R3: While the run bit is clear, the count keeps its value.
- R4: With run and mode set, the pin is sampled only at phase 9 of each machine cycle, which is clock 10 of 12. A high sample followed by a low sample in the next machine cycle adds one at phase 0 of the following machine cycle. A low pulse that does not cover a phase-9 clock is not counted.
- R5: A pin that toggles every 12 clocks (period 24) is counted once per period.
- R6: A carry out of the low byte increments the high byte in the same step.
- R7: A step taken from 0xFFFF loads the count from the reload register and sets the overflow flag. The flag also appears on `ovf_flag`.
- R8: The overflow flag stays set until a control write with bit 2 clear. If an overflow happens in the same clock as such a write, the flag ends up set.
- R9: A bus write to either count byte in the same clock as a step stores the written byte, and the step is dropped.
- R10: The register map is: address 0 = count low byte, 1 = count high byte, 2 = reload low byte, 3 = reload high byte, 4 = control. In the control register, bit 0 is run, bit 1 is mode (1 = pin events) and bit 2 is overflow. Addresses 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External event input, sampled once per machine cycle |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register select for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default values: a 12-clock machine cycle sampled at phase 9. With these values every pin pulse can be placed on a chosen clock relative to the sampling phase. Preloading the count near 0xFFFF through the bus brings the carry, the wrap-to-reload and the clash between a flag clear and an overflow into reach within a few machine cycles. A behavioural model predicts the selected read byte and the flag on every clock. This makes one-clock shifts in the step or sample phase visible.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ADR_CNT_LO = 3'd0,
        ADR_CNT_HI = 3'd1,
        ADR_RLD_LO = 3'd2,
        ADR_RLD_HI = 3'd3,
        ADR_CTL    = 3'd4
    } reg_addr_e;

    typedef enum logic {
        SRC_CYCLES = 1'b0,
        SRC_PIN    = 1'b1
    } cnt_src_e;

    typedef struct packed {
        logic       ovf;
        cnt_src_e   src;
        logic       run;
    } ctl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    function automatic logic [BYTE_W-1:0] ctl_to_byte(ctl_t c);
        logic [BYTE_W-1:0] b;
        b    = '0;
        b[0] = c.run;
        b[1] = c.src;
        b[2] = c.ovf;
        return b;
    endfunction

    function automatic cnt_t cnt_next(cnt_t c);
        return cnt_t'(c + 1'b1);
    endfunction

endpackage

// File: rtl/mc_phase_gen.sv
module mc_phase_gen #(
    parameter int CYC_LEN   = 12,
    parameter int SAMPLE_PH = 9
) (
    input  logic clk,
    input  logic rst,
    output logic cyc_start,
    output logic smp_stb
);
    localparam int PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);
    localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_PH);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (phase_q == PH_LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign cyc_start = (phase_q == '0);
    assign smp_stb   = (phase_q == PH_SMP);

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LAST) |=> (phase_q == '0));

    // R4
    single_sample_chk: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> !smp_stb);

endmodule

// File: rtl/mc_fall_sampler.sv
module mc_fall_sampler (
    input  logic clk,
    input  logic rst,
    input  logic smp_stb,
    input  logic pin,
    output logic fall_pend
);
    logic last_smp_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_smp_q <= 1'b0;
            pend_q     <= 1'b0;
        end else if (smp_stb) begin
            pend_q     <= last_smp_q & ~pin;
            last_smp_q <= pin;
        end
    end

    assign fall_pend = pend_q;

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(fall_pend));

endmodule

// File: rtl/mc_count_core.sv
module mc_count_core
    import mc_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  cnt_t              rld,
    output cnt_t              count,
    output logic              wrap
);
    localparam cnt_t CNT_MAX = '1;

    cnt_t cnt_q;
    logic any_wr;
    logic at_max;

    assign any_wr = wr_lo | wr_hi;
    assign at_max = (cnt_q == CNT_MAX);
    assign wrap   = step & at_max & ~any_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_lo) cnt_q.lo <= wr_data;
            if (wr_hi) cnt_q.hi <= wr_data;
        end else if (step) begin
            cnt_q <= at_max ? rld : cnt_next(cnt_q);
        end
    end

    assign count = cnt_q;

    // R7
    reload_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_max && !any_wr) |=> (count == $past(rld)));

    // R9
    lo_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (count.lo == $past(wr_data)));

    // R9
    hi_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (count.hi == $past(wr_data)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !any_wr) |=> $stable(count));

endmodule

// File: rtl/mc_timer.sv
module mc_timer
    import mc_timer_pkg::*;
#(
    parameter int CYC_LEN   = 12,
    parameter int SAMPLE_PH = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              ovf_flag
);
    ctl_t  ctl_q;
    cnt_t  rld_q;
    cnt_t  count;
    logic  cyc_start;
    logic  smp_stb;
    logic  fall_pend;
    logic  step;
    logic  wrap;
    logic  wr_lo;
    logic  wr_hi;
    logic  wr_ctl;
    reg_addr_e addr;

    assign addr   = reg_addr_e'(bus_addr);
    assign wr_lo  = bus_wr && (addr == ADR_CNT_LO);
    assign wr_hi  = bus_wr && (addr == ADR_CNT_HI);
    assign wr_ctl = bus_wr && (addr == ADR_CTL);

    mc_phase_gen #(
        .CYC_LEN   (CYC_LEN),
        .SAMPLE_PH (SAMPLE_PH)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .smp_stb   (smp_stb)
    );

    mc_fall_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .smp_stb   (smp_stb),
        .pin       (ext_pin),
        .fall_pend (fall_pend)
    );

    always_comb begin
        step = 1'b0;
        if (ctl_q.run && cyc_start)
            step = (ctl_q.src == SRC_PIN) ? fall_pend : 1'b1;
    end

    mc_count_core u_core (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (bus_wdata),
        .rld     (rld_q),
        .count   (count),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            rld_q <= '0;
        end else begin
            if (bus_wr && addr == ADR_RLD_LO) rld_q.lo <= bus_wdata;
            if (bus_wr && addr == ADR_RLD_HI) rld_q.hi <= bus_wdata;
            if (wr_ctl) begin
                ctl_q.run <= bus_wdata[0];
                ctl_q.src <= cnt_src_e'(bus_wdata[1]);
            end
            ctl_q.ovf <= wrap | (wr_ctl ? bus_wdata[2] : ctl_q.ovf);
        end
    end

    always_comb begin
        case (addr)
            ADR_CNT_LO: bus_rdata = count.lo;
            ADR_CNT_HI: bus_rdata = count.hi;
            ADR_RLD_LO: bus_rdata = rld_q.lo;
            ADR_RLD_HI: bus_rdata = rld_q.hi;
            ADR_CTL:    bus_rdata = ctl_to_byte(ctl_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign ovf_flag = ctl_q.ovf;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !wr_ctl) |=> ovf_flag);

    // R7
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag);

    // R3
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.run && !wr_lo && !wr_hi) |=> $stable(count));

endmodule

// File: tb/mc_timer_bench.sv
module mc_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_phase, m_cnt, m_rld;
    bit m_run, m_mode, m_ovf, m_prev, m_pend;
    bit mb_cw, mb_step, mb_set;

    always #2 clk = ~clk;

    mc_timer u_mc_timer (
        .clk       (clk),
        .rst       (rst),
        .ext_pin   (ext_pin),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ovf_flag  (ovf_flag)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_rld = 0;
            m_run = 0; m_mode = 0; m_ovf = 0; m_prev = 0; m_pend = 0;
        end else begin
            mb_cw   = bus_wr && (bus_addr < 3'd2);
            mb_step = m_run && (m_phase == 0) && (m_mode ? m_pend : 1'b1) && !mb_cw;
            mb_set  = 0;
            if (bus_wr && bus_addr == 3'd0) m_cnt = (m_cnt & 'hFF00) | int'(bus_wdata);
            if (bus_wr && bus_addr == 3'd1) m_cnt = (m_cnt & 'h00FF) | (int'(bus_wdata) << 8);
            if (mb_step) begin
                if (m_cnt == 'hFFFF) begin m_cnt = m_rld; mb_set = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (bus_wr && bus_addr == 3'd2) m_rld = (m_rld & 'hFF00) | int'(bus_wdata);
            if (bus_wr && bus_addr == 3'd3) m_rld = (m_rld & 'h00FF) | (int'(bus_wdata) << 8);
            if (bus_wr && bus_addr == 3'd4) begin
                m_run = bus_wdata[0]; m_mode = bus_wdata[1]; m_ovf = bus_wdata[2];
            end
            if (mb_set) m_ovf = 1;
            if (m_phase == 9) begin m_pend = m_prev && !ext_pin; m_prev = ext_pin; end
            m_phase = (m_phase == 11) ? 0 : m_phase + 1;
        end
    end

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return 8'(m_cnt);
            3'd1: return 8'(m_cnt >> 8);
            3'd2: return 8'(m_rld);
            3'd3: return 8'(m_rld >> 8);
            3'd4: return {5'd0, m_ovf, m_mode, m_run};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    function automatic string tag_of(logic [2:0] a);
        if (a < 3'd2) return "R2";
        if (a == 3'd4) return "R8";
        return "R10";
    endfunction

    // model comparison on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tag_of(bus_addr), int'(bus_rdata), int'(exp_rd(bus_addr)));
            chk("R7", int'(ovf_flag), int'(m_ovf));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic look(logic [2:0] a, output int v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = int'(bus_rdata);
    endtask

    task automatic align(int ph);
        do begin @(posedge clk); #1; end while (m_phase != ph);
    endtask

    int a, b, v;

    initial begin
        tick(3);
        rst = 0;
        // R1: reset values
        for (int i = 0; i < 5; i++) begin
            look(3'(i), v);
            chk("R1", v, 0);
        end
        chk("R1", int'(ovf_flag), 0);

        // R2: timer mode, one step per 12 clocks
        wr(3'd4, 8'h01);
        bus_addr = 3'd0;
        @(negedge clk); a = int'(bus_rdata);
        repeat (120) @(negedge clk);
        b = int'(bus_rdata);
        chk("R2", (b - a) & 'hFF, 10);

        // R3: stopped count holds
        wr(3'd4, 8'h00);
        look(3'd0, a);
        tick(50);
        look(3'd0, b);
        chk("R3", b, a);

        // R6: carry into high byte
        wr(3'd0, 8'hFE);
        wr(3'd1, 8'h12);
        wr(3'd4, 8'h01);
        tick(36);
        look(3'd1, v);
        chk("R6", v, 'h13);

        // R7: wrap loads reload value and sets flag
        wr(3'd4, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h40);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'h01);
        tick(20);
        look(3'd1, v);
        chk("R7", v, 'h40);
        chk("R7", int'(ovf_flag), 1);

        // R8: flag sticky, cleared by control write with bit 2 clear
        wr(3'd4, 8'h05);
        tick(30);
        chk("R8", int'(ovf_flag), 1);
        wr(3'd4, 8'h01);
        tick(2);
        chk("R8", int'(ovf_flag), 0);

        // R8: set wins over clear in same clock
        wr(3'd4, 8'h05);
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        align(0);
        bus_wr = 1; bus_addr = 3'd4; bus_wdata = 8'h01;
        @(posedge clk); #1; bus_wr = 0;
        @(negedge clk);
        chk("R8", int'(ovf_flag), 1);
        look(3'd1, v);
        chk("R8", v, 'h40);

        // R9: count write beats step
        align(0);
        bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'h55;
        @(posedge clk); #1; bus_wr = 0;
        look(3'd0, v);
        chk("R9", v, 'h55);

        // R4: counter mode
        wr(3'd4, 8'h03);
        ext_pin = 1;
        tick(36);
        look(3'd0, a);
        align(2);
        ext_pin = 0; tick(3); ext_pin = 1;
        tick(36);
        look(3'd0, b);
        chk("R4", b, a);
        align(8);
        ext_pin = 0; @(posedge clk); #1; ext_pin = 1;
        tick(36);
        look(3'd0, b);
        chk("R4", b, a);
        align(9);
        ext_pin = 0; @(posedge clk); #1; ext_pin = 1;
        tick(36);
        look(3'd0, b);
        chk("R4", b, (a + 1) & 'hFF);
        ext_pin = 0; tick(48);
        look(3'd0, a);
        chk("R4", a, (b + 1) & 'hFF);

        // R5: fastest countable rate
        ext_pin = 1; tick(24);
        look(3'd0, a);
        repeat (10) begin
            ext_pin = 0; tick(12);
            ext_pin = 1; tick(12);
        end
        tick(24);
        look(3'd0, b);
        chk("R5", (b - a) & 'hFF, 10);

        // R10: unmapped addresses
        wr(3'd6, 8'hFF);
        look(3'd6, v);
        chk("R10", v, 0);
        look(3'd4, v);
        chk("R10", v, 'h03);
        look(3'd2, v);
        chk("R10", v, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule